// File: doc/BRIEF.md
# Left-Justified Stereo Audio Serial Slave Port

This block connects internal logic to an external audio converter or transceiver that owns the serial clocks. The external master drives the bit clock and the word-select clock. The block samples both clocks and the serial input line into the system clock domain. It detects their edges there and tracks the slot structure of each stereo frame.

A frame holds 64 bit clocks. The left slot comes first and the right slot second, and each slot is 32 bits long. The data is left-justified, so the first bit of a slot is its most significant bit and it follows the word-select transition directly. Only the upper 16 bits of a slot carry audio. The receive side assembles these bits into a 16-bit sample per channel and raises a one-cycle strobe for it. The transmit side sends a 16-bit sample per channel and fills the remaining positions with zeros.

A loopback mode sends each received sample back out on the same channel in the next frame, attenuated by a quarter through an arithmetic right shift. A slot that ends before its 32nd bit clock raises a framing error pulse.

Top module: `lj_audio_slave`

## Requirements
- R1: After reset, `sdout`, `frame_err`, both valid strobes and both `rx_*` sample outputs are 0.
- R2: The 16 bits sampled on the first 16 rising bit-clock edges of a slot form the received sample, first bit = bit 15. A slot with word-select low is the left channel; a slot with word-select high is the right channel. Bit positions 16 to 31 of a slot do not affect any output. A slot with fewer than 16 bit clocks produces no sample.
- R3: `rx_left_valid` and `rx_right_valid` each last one system clock per captured sample and are never high together; the matching `rx_*` output holds the new sample while its strobe is high and afterwards.
- R4: Each transmitted slot starts with bit 15 of its sample at the word-select transition. Every following falling bit-clock edge advances one bit. Slot positions 16 to 31 are driven as 0.
- R5: The transmit sample of a slot is taken at the word-select transition that opens the slot; changes to `tx_left`/`tx_right` during the slot do not alter the bits of that slot.
- R6: When `tx_avail` is 0 at the start of a slot (and loopback is off), the whole slot is sent as zeros.
- R7: When `loop_en` is 1 at the start of a slot, the slot carries the most recent sample received on the same channel, shifted right by 2 with bit 15 copied into bits 15 and 14; `tx_left`, `tx_right` and `tx_avail` are ignored.
- R8: A word-select transition that arrives when fewer than 32 rising bit-clock edges have occurred since the previous transition produces a one-cycle `frame_err` pulse. The bit count restarts at every transition. A full slot and the first transition after reset produce no pulse.
- R9: `sdout` changes only in the system cycle after a detected falling bit-clock edge or word-select transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Bit clock from the external master |
| lrck_in | input | 1 | Word-select clock from the master (0 = left, 1 = right) |
| sdin | input | 1 | Serial data from the converter |
| sdout | output | 1 | Serial data to the converter |
| loop_en | input | 1 | Loopback-attenuate mode select |
| tx_avail | input | 1 | Transmit samples present; 0 sends zero slots |
| tx_left | input | 16 | Left sample to transmit |
| tx_right | input | 16 | Right sample to transmit |
| rx_left | output | 16 | Last received left sample |
| rx_right | output | 16 | Last received right sample |
| rx_left_valid | output | 1 | One-cycle strobe: new left sample |
| rx_right_valid | output | 1 | One-cycle strobe: new right sample |
| frame_err | output | 1 | One-cycle pulse: slot shorter than 32 bit clocks |

## Verification
The assertions assume that the bit clock runs slowly enough for each of its edges to appear as a separate event after synchronisation. They also assume that word-select changes only together with a falling bit-clock edge, so that a transition and a rising edge never fall in the same system cycle. The bench drives the bit clock with eight system cycles per phase. It changes word-select and data only at the falling edge, and it changes `loop_en` and `tx_avail` only between slots. Under these conditions the one-cycle strobes, their mutual exclusion and the hold of `sdout` between serial events must follow from the design.

// File: rtl/lj_audio_pkg.sv
package lj_audio_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } lj_chan_e;
endpackage

// File: rtl/lj_sync.sv
module lj_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d[b]};
    end
    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/lj_slot_tracker.sv
module lj_slot_tracker
  import lj_audio_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int CNT_W  = $clog2(SLOT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrck_edge,
  input  logic             lrck_lvl,
  input  logic             sclk_rise,
  output lj_chan_e         chan,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             started,
  output logic             frame_err
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOT_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan      <= CH_LEFT;
      bit_cnt   <= '0;
      started   <= 1'b0;
      frame_err <= 1'b0;
    end else if (lrck_edge) begin
      frame_err <= started && (bit_cnt < FULL);
      bit_cnt   <= '0;
      chan      <= lj_chan_e'(lrck_lvl);
      started   <= 1'b1;
    end else begin
      frame_err <= 1'b0;
      if (sclk_rise && bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lj_rx_deser.sv
module lj_rx_deser
  import lj_audio_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_rise,
  input  logic                sdin_s,
  input  logic                started,
  input  lj_chan_e            chan,
  input  logic [CNT_W-1:0]    bit_cnt,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_left_valid,
  output logic                rx_right_valid
);
  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-2:0] shift_q;
  logic [SAMPLE_W-1:0] word;
  logic                capture;
  logic                complete;

  assign word     = {shift_q, sdin_s};
  assign capture  = sclk_rise && started && (bit_cnt < LIMIT);
  assign complete = capture && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q        <= '0;
      rx_left        <= '0;
      rx_right       <= '0;
      rx_left_valid  <= 1'b0;
      rx_right_valid <= 1'b0;
    end else begin
      rx_left_valid  <= 1'b0;
      rx_right_valid <= 1'b0;
      if (capture) shift_q <= word[SAMPLE_W-2:0];
      if (complete) begin
        if (chan == CH_LEFT) begin
          rx_left       <= word;
          rx_left_valid <= 1'b1;
        end else begin
          rx_right       <= word;
          rx_right_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lj_tx_ser.sv
module lj_tx_ser #(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_W    = 32,
  parameter int ATT_SHIFT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lrck_edge,
  input  logic                lrck_lvl,
  input  logic                sclk_fall,
  input  logic                loop_en,
  input  logic                tx_avail,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  input  logic [SAMPLE_W-1:0] rx_left,
  input  logic [SAMPLE_W-1:0] rx_right,
  output logic                sdout
);
  localparam int PAD_W = SLOT_W - SAMPLE_W;

  function automatic logic [SAMPLE_W-1:0] attenuate(input logic [SAMPLE_W-1:0] s);
    return SAMPLE_W'($signed(s) >>> ATT_SHIFT);
  endfunction

  function automatic logic [SLOT_W-1:0] pad_slot(input logic [SAMPLE_W-1:0] s);
    return SLOT_W'(s) << PAD_W;
  endfunction

  logic [SAMPLE_W-1:0] next_sample;
  logic [SLOT_W-1:0]   shreg_q;

  always_comb begin
    if (loop_en)       next_sample = attenuate(lrck_lvl ? rx_right : rx_left);
    else if (tx_avail) next_sample = lrck_lvl ? tx_right : tx_left;
    else               next_sample = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         shreg_q <= '0;
    else if (lrck_edge) shreg_q <= pad_slot(next_sample);
    else if (sclk_fall) shreg_q <= {shreg_q[SLOT_W-2:0], 1'b0};
  end

  assign sdout = shreg_q[SLOT_W-1];
endmodule

// File: rtl/lj_audio_slave.sv
module lj_audio_slave
  import lj_audio_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_W    = 32,
  parameter int ATT_SHIFT = 2,
  parameter int SYNC_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_in,
  input  logic                lrck_in,
  input  logic                sdin,
  output logic                sdout,
  input  logic                loop_en,
  input  logic                tx_avail,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_left_valid,
  output logic                rx_right_valid,
  output logic                frame_err
);
  localparam int CNT_W = $clog2(SLOT_W + 1);

  logic [2:0] pins_s;
  logic       sclk_s, lrck_s, sdin_s;
  logic       sclk_d, lrck_d;
  logic       sclk_rise, sclk_fall, lrck_edge;

  lj_chan_e         chan;
  logic [CNT_W-1:0] bit_cnt;
  logic             started;

  lj_sync #(.W(3), .STAGES(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sdin, lrck_in, sclk_in}),
    .q     (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign lrck_s = pins_s[1];
  assign sdin_s = pins_s[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      lrck_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      lrck_d <= lrck_s;
    end
  end

  // serial events in the system domain, visible to the checker
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign lrck_edge = lrck_s ^ lrck_d;

  lj_slot_tracker #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .lrck_edge (lrck_edge),
    .lrck_lvl  (lrck_s),
    .sclk_rise (sclk_rise),
    .chan      (chan),
    .bit_cnt   (bit_cnt),
    .started   (started),
    .frame_err (frame_err)
  );

  lj_rx_deser #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_rx (
    .clk            (clk),
    .rst_n          (rst_n),
    .sclk_rise      (sclk_rise),
    .sdin_s         (sdin_s),
    .started        (started),
    .chan           (chan),
    .bit_cnt        (bit_cnt),
    .rx_left        (rx_left),
    .rx_right       (rx_right),
    .rx_left_valid  (rx_left_valid),
    .rx_right_valid (rx_right_valid)
  );

  lj_tx_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .ATT_SHIFT(ATT_SHIFT)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .lrck_edge (lrck_edge),
    .lrck_lvl  (lrck_s),
    .sclk_fall (sclk_fall),
    .loop_en   (loop_en),
    .tx_avail  (tx_avail),
    .tx_left   (tx_left),
    .tx_right  (tx_right),
    .rx_left   (rx_left),
    .rx_right  (rx_right),
    .sdout     (sdout)
  );
endmodule

// File: rtl/lj_audio_slave_chk.sv
module lj_audio_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic lrck_edge,
  input logic sdout,
  input logic rx_left_valid,
  input logic rx_right_valid,
  input logic frame_err
);
  assert_valid_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_left_valid && rx_right_valid));

  assert_left_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_left_valid |=> !rx_left_valid);

  assert_right_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_right_valid |=> !rx_right_valid);

  assert_valid_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_left_valid || rx_right_valid) |-> $past(sclk_rise));

  assert_err_after_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(lrck_edge));

  assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  assert_sdout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_fall || lrck_edge) |=> $stable(sdout));
endmodule

bind lj_audio_slave lj_audio_slave_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sclk_rise      (sclk_rise),
  .sclk_fall      (sclk_fall),
  .lrck_edge      (lrck_edge),
  .sdout          (sdout),
  .rx_left_valid  (rx_left_valid),
  .rx_right_valid (rx_right_valid),
  .frame_err      (frame_err)
);

// File: tb/lj_audio_slave_test.sv
module lj_audio_slave_test;
  localparam int H = 8;  // system cycles per bit-clock phase

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, lrck = 1'b0, sdin = 1'b0;
  logic        sdout;
  logic        loop_en = 1'b0, tx_avail = 1'b0;
  logic [15:0] tx_left = '0, tx_right = '0;
  logic [15:0] rx_left, rx_right;
  logic        rx_left_valid, rx_right_valid, frame_err;

  always #4 clk = ~clk;

  lj_audio_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .lrck_in(lrck), .sdin(sdin),
    .sdout(sdout), .loop_en(loop_en), .tx_avail(tx_avail),
    .tx_left(tx_left), .tx_right(tx_right), .rx_left(rx_left), .rx_right(rx_right),
    .rx_left_valid(rx_left_valid), .rx_right_valid(rx_right_valid), .frame_err(frame_err)
  );

  int checks = 0, fails = 0, err_seen = 0;
  logic [16:0] rx_q[$];        // {channel, sample}
  logic [15:0] seen_l = '0, seen_r = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] quarter(input logic [15:0] s);
    return {s[15], s[15], s[15:2]};
  endfunction

  // monitor: scoreboard for received samples, counter for framing pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_err) err_seen++;
      if (rx_left_valid || rx_right_valid) begin
        if (rx_q.size() == 0) begin
          check("R2 unexpected sample strobe", {15'd0, rx_right_valid, rx_right_valid ? rx_right : rx_left}, 32'hFFFF_FFFF);
        end else begin
          logic [16:0] e;
          e = rx_q.pop_front();
          check("R3 strobe exclusive", {31'd0, rx_left_valid & rx_right_valid}, 32'd0);
          check("R2 channel and sample", {15'd0, rx_right_valid, rx_right_valid ? rx_right : rx_left}, {15'd0, e});
        end
      end
    end
  end

  // driver: one slot; checks the transmitted bits as the external receiver sees them
  task automatic drive_slot(input logic ch, input logic [15:0] data, input logic [15:0] pad,
                            input int nbits, input logic mid_chg, input logic [15:0] alt);
    logic [31:0] word, exp_tx, cap, mask;
    word = {data, pad};
    cap = '0;
    if (loop_en)       exp_tx = {quarter(ch ? seen_r : seen_l), 16'h0};
    else if (tx_avail) exp_tx = {ch ? tx_right : tx_left, 16'h0};
    else               exp_tx = '0;
    if (nbits >= 16) rx_q.push_back({ch, data});
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sclk = 1'b0;
      if (i == 0) lrck = ch;
      sdin = word[31-i];
      if (mid_chg && i == 8) begin
        tx_left = alt;
        tx_right = alt;
      end
      repeat (H) @(negedge clk);
      cap = {cap[30:0], sdout};
      sclk = 1'b1;
      repeat (H - 1) @(negedge clk);
    end
    if (nbits >= 16) begin
      if (ch) seen_r = data; else seen_l = data;
    end
    mask = 32'hFFFF_FFFF << (32 - nbits);
    check("R4 R5 R6 R7 transmitted slot", cap << (32 - nbits), exp_tx & mask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int e0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    check("R1 sdout", {31'd0, sdout}, 32'd0);
    check("R1 strobes/err", {29'd0, rx_left_valid, rx_right_valid, frame_err}, 32'd0);
    check("R1 rx outputs", {rx_left, rx_right}, 32'd0);

    // preamble right slot opens framing; first transition gives no error (R8)
    tx_avail = 1'b1;
    tx_left = 16'h7E81;
    tx_right = 16'hA5C3;
    drive_slot(1'b1, 16'h1234, 16'hFFFF, 32, 1'b0, 16'h0);
    // normal frames (R2 R4), padding bits differ to show they are ignored
    drive_slot(1'b0, 16'h8001, 16'hBEEF, 32, 1'b0, 16'h0);
    tx_right = 16'h0F0F;
    drive_slot(1'b1, 16'h7FFF, 16'h0001, 32, 1'b0, 16'h0);
    check("R3 rx_right holds", {16'd0, rx_right}, {16'd0, 16'h7FFF});
    check("R8 no error for full slots", err_seen, 0);
    tx_left = 16'h55AA;
    drive_slot(1'b0, 16'hC3C3, 16'h0000, 32, 1'b0, 16'h0);
    drive_slot(1'b1, 16'h0000, 16'hFFFF, 32, 1'b0, 16'h0);
    // R5 change mid slot: current slot keeps the latched sample
    tx_left = 16'h1357;
    drive_slot(1'b0, 16'hFFFF, 16'h1234, 32, 1'b1, 16'hECA8);
    check("R5 next slot uses new input", {16'd0, tx_right}, {16'd0, 16'hECA8});
    drive_slot(1'b1, 16'h2468, 16'h0F0F, 32, 1'b0, 16'h0);
    // R6 no transmit data
    tx_avail = 1'b0;
    drive_slot(1'b0, 16'h4000, 16'h8000, 32, 1'b0, 16'h0);
    drive_slot(1'b1, 16'hBFFF, 16'h7FFF, 32, 1'b0, 16'h0);
    // R7 loopback: tx inputs and tx_avail ignored
    loop_en = 1'b1;
    tx_avail = 1'b1;
    tx_left = 16'hDEAD;
    tx_right = 16'hBEEF;
    drive_slot(1'b0, 16'h8003, 16'h5555, 32, 1'b0, 16'h0);
    drive_slot(1'b1, 16'h7FFD, 16'hAAAA, 32, 1'b0, 16'h0);
    drive_slot(1'b0, 16'h0005, 16'h0000, 32, 1'b0, 16'h0);
    drive_slot(1'b1, 16'hFFFE, 16'h0000, 32, 1'b0, 16'h0);
    loop_en = 1'b0;
    // R8 short slots
    e0 = err_seen;
    drive_slot(1'b0, 16'h6B6B, 16'hFFFF, 20, 1'b0, 16'h0);
    drive_slot(1'b1, 16'h1111, 16'h0000, 32, 1'b0, 16'h0);
    check("R8 short slot flagged once", err_seen, e0 + 1);
    drive_slot(1'b0, 16'h2222, 16'h0000, 32, 1'b0, 16'h0);
    check("R8 full slot after short not flagged", err_seen, e0 + 1);
    drive_slot(1'b1, 16'h3333, 16'h0000, 10, 1'b0, 16'h0);
    drive_slot(1'b0, 16'h4444, 16'h0000, 32, 1'b0, 16'h0);
    check("R8 very short slot flagged", err_seen, e0 + 2);
    check("R2 short slot leaves rx_right", {16'd0, rx_right}, {16'd0, 16'h1111});
    drive_slot(1'b1, 16'h5555, 16'h0000, 32, 1'b0, 16'h0);
    repeat (40) @(negedge clk);
    check("R2 all expected samples delivered", rx_q.size(), 0);
    check("R8 total error count", err_seen, e0 + 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule